// File: doc/BRIEF.md
# Two-Bank SDRAM Precharge Tracker

This block follows the command stream a controller issues to a two-bank synchronous DRAM and keeps track of whether each bank currently has a row open. It decodes activate, read, write and precharge from the row strobe, column strobe and write-enable strobe. It works out which bank each command addresses. For every bank that begins to close, it raises a one-cycle precharge-start pulse. The pulse comes either at once, for an explicit precharge, or at a computed point near the end of a burst that was issued with the auto-precharge address bit set.

The tracker also enforces the bank timing rules. An explicit precharge that comes too early after a read or write burst is rejected, and so is a read or write to a closed bank or an activate to an open bank. A rejected command leaves all state untouched and raises an error flag one cycle later. A burst-end strobe lets the controller cut short a pending auto-precharge burst. The block holds no data path and does no refresh.

Top module: `bank_precharge_tracker`

## Requirements
- R1: A command is taken only in a cycle with `cs_n` low. With strobes (`ras_n`,`cas_n`,`we_n`) the encodings are activate 0,1,1; read 1,0,1; write 1,0,0; precharge 0,1,0. Every other encoding, and any cycle with `cs_n` high, has no effect on bank state, pulses or the error flag.
- R2: For activate, read and write, `addr11` selects the bank: 0 is bank A (index 0) and 1 is bank B (index 1). An activate to a closed bank sets its `bank_open` bit from the next cycle.
- R3: For a precharge, `addr10` high selects both banks. `addr10` low selects bank A when `addr11` is 0 and bank B when it is 1. Each selected open bank pulses its `pre_start` bit in the command cycle and reads closed from the next cycle. A selected closed bank gives no pulse and no error.
- R4: A read issued in cycle T with `addr10` high pulses `pre_start` of its bank in cycle T+BL and closes the bank from T+BL+1, whatever the CAS latency.
- R5: A write issued in cycle T with `addr10` high pulses `pre_start` in cycle T+BL when `cas_lat` is 1 or 2, and in T+BL+1 when `cas_lat` is 3.
- R6: `burst_code` values 0, 1, 2 and 3 give a burst length BL of 1, 2, 4 and 8, sampled with the read or write command.
- R7: After a read in cycle T, an explicit precharge to that bank is legal from cycle T+BL. An earlier precharge is an error.
- R8: After a write in cycle T, an explicit precharge to that bank is legal from cycle T+BL-1+T_WR. An earlier precharge is an error.
- R9: An error is a read or write to a closed bank, a read or write to a bank with an auto-precharge pending, or an activate to an open bank. An error raises `cmd_illegal` in the next cycle for one cycle and leaves bank state unchanged.
- R10: `burst_end` high in cycle E while a bank has an auto-precharge pending moves that bank's pulse to E+1 for a read or a write at `cas_lat` 1 or 2, and to E+2 for a write at `cas_lat` 3.
- R11: After a reset cycle, both banks read closed, no pulse is raised and `cmd_illegal` is low.
- R12: A both-bank precharge in which any selected open bank is still inside its recovery window is rejected as a whole. No bank closes and no pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr10 | input | 1 | Auto-precharge flag for read/write; all-bank flag for precharge |
| addr11 | input | 1 | Bank select |
| cas_lat | input | 2 | CAS latency, 1 to 3 |
| burst_code | input | 2 | Burst length code |
| burst_end | input | 1 | Cuts short a pending auto-precharge burst |
| bank_open | output | 2 | Per-bank open state, bit 0 is bank A |
| pre_start | output | 2 | Per-bank precharge-start pulse |
| cmd_illegal | output | 1 | Error flag, one cycle after the offending command |

## Verification
The assertions check on every cycle the invariants of bank state. A pending auto-precharge or a running recovery window exists only on an open bank. A start pulse only ever closes an open bank. An activate opens its bank. A rejected command freezes the open state. Only the bench's scenarios can show that each pulse falls on the exact cycle that burst length, CAS latency, read or write, and burst-end timing call for. The same holds for the edges of the recovery window after reads and writes, and for the masking of deselected and unrelated commands.

// File: rtl/bpt_pkg.sv
// Package: shared command type and strobe decoding for the precharge tracker.
// Assumes active-low strobes sampled on the rising clock edge.
package bpt_pkg;

    typedef enum logic [2:0] {
        BPT_NOP,
        BPT_ACT,
        BPT_RD,
        BPT_WR,
        BPT_PRE,
        BPT_OTHER
    } bpt_cmd_e;

    // Map chip select and the three strobes to a command kind.
    function automatic bpt_cmd_e bpt_decode(input logic cs_n, input logic ras_n,
                                            input logic cas_n, input logic we_n);
        bpt_cmd_e c;
        if (cs_n) begin
            c = BPT_NOP;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  c = BPT_ACT;
                3'b101:  c = BPT_RD;
                3'b100:  c = BPT_WR;
                3'b010:  c = BPT_PRE;
                3'b111:  c = BPT_NOP;
                default: c = BPT_OTHER;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/bpt_cmd_decode.sv
// Command decoder: turns strobes and address bits into one-hot command
// flags, the addressed bank, the precharge bank mask and the burst length.
// Assumes burst_code selects a power-of-two length of 1 to 8 beats.
module bpt_cmd_decode
    import bpt_pkg::*;
#(
    parameter int BEAT_W = 4
) (
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              addr10,
    input  logic              addr11,
    input  logic [1:0]        burst_code,
    output logic              is_act,
    output logic              is_rd,
    output logic              is_wr,
    output logic              is_pre,
    output logic              bank_sel,
    output logic              ap_req,
    output logic [1:0]        pre_mask,
    output logic [BEAT_W-1:0] beats
);

    bpt_cmd_e cmd;

    // Classify the command of this cycle.
    always_comb begin
        cmd    = bpt_decode(cs_n, ras_n, cas_n, we_n);
        is_act = (cmd == BPT_ACT);
        is_rd  = (cmd == BPT_RD);
        is_wr  = (cmd == BPT_WR);
        is_pre = (cmd == BPT_PRE);
    end

    // Derive the bank operands from the address bits.
    always_comb begin
        bank_sel = addr11;
        ap_req   = addr10;
        if (addr10)      pre_mask = 2'b11;
        else if (addr11) pre_mask = 2'b10;
        else             pre_mask = 2'b01;
        beats = BEAT_W'(1) << burst_code;
    end

endmodule

// File: rtl/bpt_bank.sv
// Per-bank tracker: holds the open state, a recovery-window counter that
// blocks early explicit precharge, and an auto-precharge countdown that
// fires a one-cycle start pulse. Assumes the caller only asserts do_act,
// do_rw and do_pre for commands already judged legal.
module bpt_bank #(
    parameter int BEAT_W = 4,
    parameter int GW     = 4,
    parameter int CW     = 4,
    parameter int T_WR   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_act,
    input  logic              do_rw,
    input  logic              rw_is_wr,
    input  logic              rw_ap,
    input  logic              do_pre,
    input  logic              burst_end,
    input  logic              cl3,
    input  logic [BEAT_W-1:0] beats,
    output logic              open_o,
    output logic              pend_o,
    output logic              busy_o,
    output logic              fire_o
);

    logic          open_q;
    logic          pend_q;
    logic          wr3_q;
    logic [GW-1:0] guard_q;
    logic [CW-1:0] cnt_q;
    logic [GW-1:0] g_load;
    logic [CW-1:0] d_load;

    // Reload values: recovery window minus one and start delay minus one.
    always_comb begin
        g_load = GW'(beats) - GW'(1) + (rw_is_wr ? GW'(T_WR - 1) : GW'(0));
        d_load = CW'(beats) - CW'(1) + ((rw_is_wr && cl3) ? CW'(1) : CW'(0));
    end

    assign fire_o = pend_q && (cnt_q == '0);
    assign open_o = open_q;
    assign pend_o = pend_q;
    assign busy_o = (guard_q != '0);

    // Bank state update, closing has priority over any other change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q  <= 1'b0;
            pend_q  <= 1'b0;
            wr3_q   <= 1'b0;
            guard_q <= '0;
            cnt_q   <= '0;
        end else if (fire_o || do_pre) begin
            open_q  <= 1'b0;
            pend_q  <= 1'b0;
            guard_q <= '0;
            cnt_q   <= '0;
        end else if (do_act) begin
            open_q <= 1'b1;
        end else if (do_rw) begin
            guard_q <= g_load;
            if (rw_ap) begin
                pend_q <= 1'b1;
                cnt_q  <= d_load;
                wr3_q  <= rw_is_wr && cl3;
            end
        end else begin
            if (guard_q != '0) guard_q <= guard_q - GW'(1);
            if (pend_q) begin
                if (burst_end)          cnt_q <= CW'(wr3_q);
                else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    // A pending auto-precharge only exists on an open bank.
    p_pend_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> open_q);

    // A running recovery window only exists on an open bank.
    p_busy_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> open_q);

    // An automatic start leaves the bank closed with nothing pending.
    p_fire_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> (!open_q && !pend_q));

    // An accepted activate opens the bank.
    p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (do_act && !fire_o) |=> open_q);

endmodule

// File: rtl/bank_precharge_tracker.sv
// Top level: decodes commands, judges their legality against the state of
// both banks, steers accepted commands to the per-bank trackers and
// registers the error flag. Assumes cas_lat and burst_code are stable
// while a command is issued; cas_lat of 3 selects the longer write delay.
module bank_precharge_tracker #(
    parameter int T_WR = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic       addr10,
    input  logic       addr11,
    input  logic [1:0] cas_lat,
    input  logic [1:0] burst_code,
    input  logic       burst_end,
    output logic [1:0] bank_open,
    output logic [1:0] pre_start,
    output logic       cmd_illegal
);

    localparam int NBANK  = 2;
    localparam int BL_MAX = 8;
    localparam int BEAT_W = $clog2(BL_MAX + 1);
    localparam int GW     = $clog2(BL_MAX + T_WR + 1);
    localparam int CW     = $clog2(BL_MAX + 2);

    logic              is_act, is_rd, is_wr, is_pre;
    logic              bank_sel, ap_req;
    logic [1:0]        pre_mask;
    logic [BEAT_W-1:0] beats;
    logic [NBANK-1:0]  b_open, b_pend, b_busy, b_fire;
    logic [NBANK-1:0]  do_act, do_rw, do_pre;
    logic              illegal_now;
    logic              cl3;
    logic              illegal_q;

    bpt_cmd_decode #(.BEAT_W(BEAT_W)) i_decode (
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .addr10    (addr10),
        .addr11    (addr11),
        .burst_code(burst_code),
        .is_act    (is_act),
        .is_rd     (is_rd),
        .is_wr     (is_wr),
        .is_pre    (is_pre),
        .bank_sel  (bank_sel),
        .ap_req    (ap_req),
        .pre_mask  (pre_mask),
        .beats     (beats)
    );

    assign cl3 = (cas_lat == 2'd3);

    // Judge the command against the addressed banks.
    always_comb begin
        illegal_now = 1'b0;
        if (is_act && b_open[bank_sel])                            illegal_now = 1'b1;
        if ((is_rd || is_wr) && (!b_open[bank_sel] || b_pend[bank_sel])) illegal_now = 1'b1;
        if (is_pre && ((pre_mask & b_open & b_busy) != '0))        illegal_now = 1'b1;
    end

    genvar gb;
    generate
        for (gb = 0; gb < NBANK; gb++) begin : g_bank
            // Steer an accepted command to this bank.
            always_comb begin
                do_act[gb] = is_act && !illegal_now && (bank_sel == gb[0]);
                do_rw[gb]  = (is_rd || is_wr) && !illegal_now && (bank_sel == gb[0]);
                do_pre[gb] = is_pre && !illegal_now && pre_mask[gb];
            end

            bpt_bank #(
                .BEAT_W(BEAT_W),
                .GW    (GW),
                .CW    (CW),
                .T_WR  (T_WR)
            ) i_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .do_act   (do_act[gb]),
                .do_rw    (do_rw[gb]),
                .rw_is_wr (is_wr),
                .rw_ap    (ap_req),
                .do_pre   (do_pre[gb]),
                .burst_end(burst_end),
                .cl3      (cl3),
                .beats    (beats),
                .open_o   (b_open[gb]),
                .pend_o   (b_pend[gb]),
                .busy_o   (b_busy[gb]),
                .fire_o   (b_fire[gb])
            );

            assign pre_start[gb] = b_fire[gb] || (do_pre[gb] && b_open[gb]);
        end
    endgenerate

    // Register the error flag for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) illegal_q <= 1'b0;
        else        illegal_q <= illegal_now;
    end

    assign cmd_illegal = illegal_q;
    assign bank_open   = b_open;

    // A start pulse only ever concerns an open bank.
    p_pulse_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_start & ~bank_open) == '0);

    // A rejected command with no automatic start freezes the open state.
    p_reject_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_now && (b_fire == '0)) |=> $stable(bank_open));

    // An accepted all-bank precharge leaves both banks closed.
    p_all_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pre && addr10 && !illegal_now) |=> (bank_open == '0));

    // A deselected cycle steers nothing to any bank.
    p_cs_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> ((do_act | do_rw | do_pre) == '0));

endmodule

// File: tb/test_bank_precharge_tracker.sv
// Bench: behavioural reference model with absolute cycle times, compared
// against the outputs on every clock.
module test_bank_precharge_tracker;

    localparam int TWR = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic       addr10 = 1'b0, addr11 = 1'b0, burst_end = 1'b0;
    logic [1:0] cas_lat = 2'd2, burst_code = 2'd2;
    logic [1:0] bank_open, pre_start;
    logic       cmd_illegal;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    string cur_req = "R11";

    bit m_open[2];
    bit m_pend[2];
    bit m_wr3[2];
    int m_ap[2];
    int m_guard[2];
    bit m_ill_prev = 0;

    logic [1:0] nxt_cl = 2'd2, nxt_bc = 2'd2;

    always #5 clk = ~clk;

    bank_precharge_tracker #(.T_WR(TWR)) i_bank_precharge_tracker (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .addr10(addr10), .addr11(addr11), .cas_lat(cas_lat),
        .burst_code(burst_code), .burst_end(burst_end),
        .bank_open(bank_open), .pre_start(pre_start), .cmd_illegal(cmd_illegal)
    );

    task automatic check(input string what, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d cycle=%0d", cur_req, what, act, exp, cyc);
        end
    endtask

    // Compare outputs with the model, then advance the model across the edge.
    task automatic model_step();
        bit act_c, rd_c, wr_c, pre_c, ill, sel;
        bit fire[2], selp[2], busy[2];
        int bl;
        logic [1:0] exp_p, exp_o;
        act_c = !cs_n && {ras_n, cas_n, we_n} == 3'b011;
        rd_c  = !cs_n && {ras_n, cas_n, we_n} == 3'b101;
        wr_c  = !cs_n && {ras_n, cas_n, we_n} == 3'b100;
        pre_c = !cs_n && {ras_n, cas_n, we_n} == 3'b010;
        sel = addr11;
        bl = 1 << burst_code;
        for (int b = 0; b < 2; b++) begin
            fire[b] = m_pend[b] && cyc == m_ap[b];
            busy[b] = m_open[b] && cyc < m_guard[b];
            selp[b] = addr10 ? 1'b1 : (addr11 == b[0]);
        end
        ill = 0;
        if (act_c && m_open[sel]) ill = 1;
        if ((rd_c || wr_c) && (!m_open[sel] || m_pend[sel])) ill = 1;
        if (pre_c && ((selp[0] && busy[0]) || (selp[1] && busy[1]))) ill = 1;
        for (int b = 0; b < 2; b++) begin
            exp_p[b] = fire[b] || (pre_c && !ill && selp[b] && m_open[b]);
            exp_o[b] = m_open[b];
        end
        check("pre_start", pre_start, exp_p);
        check("bank_open", bank_open, exp_o);
        check("cmd_illegal", cmd_illegal, m_ill_prev);
        for (int b = 0; b < 2; b++) begin
            if (fire[b] || (pre_c && !ill && selp[b])) begin
                m_open[b] = 0; m_pend[b] = 0; m_guard[b] = 0;
            end else if (act_c && !ill && sel == b[0]) begin
                m_open[b] = 1;
            end else if ((rd_c || wr_c) && !ill && sel == b[0]) begin
                m_guard[b] = rd_c ? cyc + bl : cyc + bl - 1 + TWR;
                if (addr10) begin
                    m_pend[b] = 1;
                    m_wr3[b]  = wr_c && cas_lat == 2'd3;
                    m_ap[b]   = cyc + bl + (m_wr3[b] ? 1 : 0);
                end
            end else if (m_pend[b] && burst_end) begin
                m_ap[b] = cyc + 1 + (m_wr3[b] ? 1 : 0);
            end
        end
        m_ill_prev = ill;
    endtask

    task automatic drive(input logic c, input logic r, input logic ca, input logic w,
                         input logic x10, input logic x11, input logic be);
        @(negedge clk);
        cs_n = c; ras_n = r; cas_n = ca; we_n = w;
        addr10 = x10; addr11 = x11; burst_end = be;
        cas_lat = nxt_cl; burst_code = nxt_bc;
        #4;
        if (rst_n) model_step();
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1, 1, 1, 1, 0, 0, 0);
    endtask
    task automatic op_act(input logic b);            drive(0, 0, 1, 1, 0, b, 0); endtask
    task automatic op_rd(input logic b, input logic ap); drive(0, 1, 0, 1, ap, b, 0); endtask
    task automatic op_wr(input logic b, input logic ap); drive(0, 1, 0, 0, ap, b, 0); endtask
    task automatic op_pre(input logic all, input logic b); drive(0, 0, 1, 0, all, b, 0); endtask
    task automatic op_bend();                        drive(1, 1, 1, 1, 0, 0, 1); endtask

    initial begin
        idle(3);
        @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R11"; idle(2);
        cur_req = "R2";  op_act(0); op_act(1); idle(1);
        cur_req = "R7";  nxt_bc = 2'd2; op_rd(0, 0); op_pre(0, 0); idle(2); op_pre(0, 0); idle(1);
        cur_req = "R3";  op_pre(1, 0); idle(1); op_act(0); op_act(1); op_pre(0, 1); idle(1);
                         op_pre(1, 0); op_pre(1, 1); idle(1);
        cur_req = "R4";  nxt_cl = 2'd2; op_act(0); op_rd(0, 1); idle(6);
                         nxt_cl = 2'd3; nxt_bc = 2'd3; op_act(1); op_rd(1, 1); idle(10);
                         nxt_bc = 2'd0; op_act(0); op_rd(0, 1); idle(3);
        cur_req = "R6";  nxt_cl = 2'd1; nxt_bc = 2'd1; op_act(1); op_rd(1, 1); idle(4);
        cur_req = "R5";  nxt_cl = 2'd2; op_act(0); op_wr(0, 1); idle(5);
                         nxt_cl = 2'd3; op_act(1); op_wr(1, 1); idle(5);
        cur_req = "R8";  nxt_cl = 2'd2; nxt_bc = 2'd2; op_act(0); op_wr(0, 0); op_pre(0, 0);
                         idle(1); op_pre(0, 0); op_pre(0, 0); idle(1);
        cur_req = "R12"; nxt_bc = 2'd0; op_act(1); op_act(0); op_wr(0, 0); op_pre(1, 0);
                         idle(1); op_pre(1, 0); idle(1);
        cur_req = "R9";  op_rd(1, 0); idle(1); op_act(0); op_act(0); idle(1);
                         nxt_bc = 2'd2; op_rd(0, 1); op_rd(0, 0); op_wr(1, 0); idle(6);
        cur_req = "R10"; nxt_cl = 2'd2; nxt_bc = 2'd3; op_act(0); op_rd(0, 1); idle(2); op_bend(); idle(3);
                         nxt_cl = 2'd3; op_act(1); op_wr(1, 1); idle(1); op_bend(); idle(4);
        cur_req = "R1";  drive(1, 0, 1, 1, 0, 0, 0); drive(1, 0, 1, 0, 1, 0, 0);
                         drive(0, 0, 0, 1, 0, 0, 0); drive(0, 0, 0, 0, 0, 0, 0);
                         drive(0, 1, 1, 0, 0, 0, 0); idle(2);
                         op_act(1); drive(1, 0, 1, 0, 1, 0, 0); idle(1); op_pre(0, 1); idle(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule